// File: doc/BRIEF.md
# Two-Level Interrupt Cascade and Acknowledge Sequencer

This block joins two eight-line priority resolvers, a primary and a secondary, into one sixteen-line interrupt system. Each resolver is reduced to what the sequencer needs: its pending-request mask, its in-service mask and its rotation offset. The block picks a candidate line for each side. A valid secondary candidate is signalled onto the primary's cascade line. The CPU interrupt line is driven from the primary's candidate.

When the CPU strobes an acknowledge, the block decides in that same cycle which resolvers to acknowledge and on which lines. In the next cycle it presents an 8-bit vector and a 4-bit system line number for one cycle. The vector is formed from a per-side base and the chosen line. The block handles a missing candidate on either side by returning the spurious line. A nested mode on the primary keeps an in-service cascade line from blocking further secondary requests.

Top module: `cas_intc_seq`

## Requirements
- R1: `cpu_int` is registered. In the cycle after any cycle where the primary has a valid candidate and `int_ack` is low, `cpu_int` is high. In the cycle after any cycle where the primary has no valid candidate, `cpu_int` is low. All outputs are low during and after reset.
- R2: A side's candidate is found by scanning its request mask from line `rot` upward, wrapping modulo 8, and taking the first set line. The candidate is valid only if this line ranks strictly ahead of the first set line of that side's in-service mask under the same scan.
- R3: When `nest_mode` is high, in-service bit 2 of the primary is left out of the primary's in-service ranking. The secondary's ranking never leaves out any bit.
- R4: In the cycle after any cycle where the secondary has a valid candidate and `int_ack` is low, `casc_set` is high. Otherwise it is low. An external primary resolver latches this pulse as an edge request on its line 2.
- R5: On an acknowledge where the primary candidate is a line L other than 2, `pri_ack` is high in the strobe cycle with `pri_ack_line`=L. In the next cycle `vec` = {`pri_base`[7:3], L} and `vec_line` = L.
- R6: On an acknowledge where the primary candidate is line 2 and the secondary has a valid candidate S, `pri_ack` (line 2) and `sec_ack` (line S) are both high in the strobe cycle. In the next cycle `vec` = {`sec_base`[7:3], S} and `vec_line` = 8+S.
- R7: On an acknowledge where the primary candidate is line 2 and the secondary has no candidate, only `pri_ack` (line 2) fires. In the next cycle `vec` = {`sec_base`[7:3], 7} and `vec_line` = 15.
- R8: On an acknowledge where the primary has no candidate, neither ack fires. In the next cycle `vec` = {`pri_base`[7:3], 7} and `vec_line` = 7.
- R9: `vec_valid` is high in exactly the cycles that follow a cycle with `int_ack` high.
- R10: In the cycle after an acknowledge, `cpu_int` is low. In the cycle after that, it reflects the candidate evaluated from the resolver state updated by the acknowledge.
- R11: Bits [2:0] of either base have no effect. The low three bits of `vec` always equal the low three bits of `vec_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_req | input | 8 | Primary unmasked pending requests |
| pri_isr | input | 8 | Primary in-service mask |
| pri_rot | input | 3 | Primary rotation offset (highest-ranked line) |
| pri_base | input | 8 | Primary vector base |
| nest_mode | input | 1 | Nested mode for the primary cascade line |
| sec_req | input | 8 | Secondary unmasked pending requests |
| sec_isr | input | 8 | Secondary in-service mask |
| sec_rot | input | 3 | Secondary rotation offset |
| sec_base | input | 8 | Secondary vector base |
| int_ack | input | 1 | CPU acknowledge strobe, one cycle |
| cpu_int | output | 1 | Interrupt request to the CPU |
| casc_set | output | 1 | Edge pulse for primary line 2 |
| pri_ack | output | 1 | Acknowledge to primary resolver |
| pri_ack_line | output | 3 | Line acknowledged on primary |
| sec_ack | output | 1 | Acknowledge to secondary resolver |
| sec_ack_line | output | 3 | Line acknowledged on secondary |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec | output | 8 | Interrupt vector |
| vec_line | output | 4 | System line number 0..15 |

## Verification
Some relations are checked on every cycle:
- the one-cycle latency of `cpu_int` and `casc_set` with respect to the candidates;
- the forced drop of `cpu_int` after an acknowledge;
- the one-to-one pairing of strobes and `vec_valid`;
- that a secondary acknowledge only accompanies a primary acknowledge of line 2;
- that acknowledged lines are actually pending;
- the agreement between the vector's low bits and the line number.

Other behaviours can only be shown by the bench's scenarios with known masks:
- the exact candidate chosen under rotation and in-service blocking;
- the effect of the nested mode;
- the vector values in the four acknowledge cases, including both spurious cases.

// File: rtl/cas_pkg.sv
package cas_pkg;
   typedef enum logic [1:0] {
      ACK_PRI       = 2'd0,
      ACK_CASC      = 2'd1,
      ACK_CASC_SPUR = 2'd2,
      ACK_PRI_SPUR  = 2'd3
   } ack_kind_e;
endpackage

// File: rtl/cas_rot.sv
module cas_rot #(
   parameter int N_LINES = 8,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] in_mask,
   input  logic [LW-1:0]      rot,
   output logic [N_LINES-1:0] out_mask
);
   for (genvar i = 0; i < N_LINES; i++) begin : g_bit
      logic [LW-1:0] idx;
      assign idx         = LW'(i) + rot;
      assign out_mask[i] = in_mask[idx];
   end
endmodule

// File: rtl/cas_prio_enc.sv
module cas_prio_enc #(
   parameter int N_LINES = 8,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] mask,
   output logic [LW:0]        rank
);
   always_comb begin
      rank = (LW+1)'(N_LINES);
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (mask[i]) rank = (LW+1)'(i);
      end
   end
endmodule

// File: rtl/cas_cand_pick.sv
module cas_cand_pick #(
   parameter int N_LINES   = 8,
   parameter bit HAS_SKIP  = 1'b0,
   parameter int SKIP_LINE = 2,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] req,
   input  logic [N_LINES-1:0] isr,
   input  logic [LW-1:0]      rot,
   input  logic               nest_en,
   output logic               cand_v,
   output logic [LW-1:0]      cand_line
);
   logic [N_LINES-1:0] isr_eff;
   logic [N_LINES-1:0] req_rot;
   logic [N_LINES-1:0] isr_rot;
   logic [LW:0]        req_rank;
   logic [LW:0]        isr_rank;

   if (HAS_SKIP) begin : g_skip
      localparam logic [N_LINES-1:0] SKIP_BIT = N_LINES'(1) << SKIP_LINE;
      assign isr_eff = nest_en ? (isr & ~SKIP_BIT) : isr;
   end else begin : g_plain
      logic unused_nest;
      assign unused_nest = nest_en;
      assign isr_eff     = isr;
   end

   cas_rot #(.N_LINES(N_LINES)) u_rot_req (
      .in_mask(req), .rot(rot), .out_mask(req_rot));
   cas_rot #(.N_LINES(N_LINES)) u_rot_isr (
      .in_mask(isr_eff), .rot(rot), .out_mask(isr_rot));

   cas_prio_enc #(.N_LINES(N_LINES)) u_enc_req (
      .mask(req_rot), .rank(req_rank));
   cas_prio_enc #(.N_LINES(N_LINES)) u_enc_isr (
      .mask(isr_rot), .rank(isr_rank));

   assign cand_v    = req_rank < isr_rank;
   assign cand_line = req_rank[LW-1:0] + rot;
endmodule

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
   import cas_pkg::*;
#(
   parameter int N_LINES   = 8,
   parameter int VEC_W     = 8,
   parameter int CASC_LINE = 2,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             int_ack,
   input  logic             pri_v,
   input  logic [LW-1:0]    pri_line,
   input  logic             sec_v,
   input  logic [LW-1:0]    sec_line,
   input  logic [VEC_W-1:0] pri_base,
   input  logic [VEC_W-1:0] sec_base,
   output logic             pri_ack,
   output logic [LW-1:0]    pri_ack_line,
   output logic             sec_ack,
   output logic [LW-1:0]    sec_ack_line,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec,
   output logic [LW:0]      vec_line
);
   localparam logic [LW-1:0] SPUR_LINE = LW'(N_LINES - 1);
   localparam logic [LW-1:0] CASC_L    = LW'(CASC_LINE);

   ack_kind_e        kind;
   logic [LW-1:0]    sel_line;
   logic [VEC_W-1:0] sel_base;
   logic [VEC_W-1:0] nxt_vec;

   always_comb begin
      if (!pri_v)                kind = ACK_PRI_SPUR;
      else if (pri_line != CASC_L) kind = ACK_PRI;
      else if (sec_v)            kind = ACK_CASC;
      else                       kind = ACK_CASC_SPUR;
   end

   always_comb begin
      unique case (kind)
         ACK_PRI:       begin sel_line = pri_line;  sel_base = pri_base; end
         ACK_CASC:      begin sel_line = sec_line;  sel_base = sec_base; end
         ACK_CASC_SPUR: begin sel_line = SPUR_LINE; sel_base = sec_base; end
         default:       begin sel_line = SPUR_LINE; sel_base = pri_base; end
      endcase
   end

   assign nxt_vec      = {sel_base[VEC_W-1:LW], sel_line};
   assign pri_ack      = int_ack && (kind != ACK_PRI_SPUR);
   assign pri_ack_line = pri_line;
   assign sec_ack      = int_ack && (kind == ACK_CASC);
   assign sec_ack_line = sec_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec       <= '0;
         vec_line  <= '0;
      end else begin
         vec_valid <= int_ack;
         if (int_ack) begin
            vec      <= nxt_vec;
            vec_line <= {(kind == ACK_CASC) || (kind == ACK_CASC_SPUR), sel_line};
         end
      end
   end
endmodule

// File: rtl/cas_intc_seq.sv
module cas_intc_seq #(
   parameter int N_LINES   = 8,
   parameter int VEC_W     = 8,
   parameter int CASC_LINE = 2,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] pri_req,
   input  logic [N_LINES-1:0] pri_isr,
   input  logic [LW-1:0]      pri_rot,
   input  logic [VEC_W-1:0]   pri_base,
   input  logic               nest_mode,
   input  logic [N_LINES-1:0] sec_req,
   input  logic [N_LINES-1:0] sec_isr,
   input  logic [LW-1:0]      sec_rot,
   input  logic [VEC_W-1:0]   sec_base,
   input  logic               int_ack,
   output logic               cpu_int,
   output logic               casc_set,
   output logic               pri_ack,
   output logic [LW-1:0]      pri_ack_line,
   output logic               sec_ack,
   output logic [LW-1:0]      sec_ack_line,
   output logic               vec_valid,
   output logic [VEC_W-1:0]   vec,
   output logic [LW:0]        vec_line
);
   if ((N_LINES < 2) || ((1 << LW) != N_LINES)) begin : g_bad_lines
      $error("N_LINES must be a power of two of at least 2");
   end
   if ((CASC_LINE < 0) || (CASC_LINE >= N_LINES)) begin : g_bad_casc
      $error("CASC_LINE must name a primary line");
   end
   if (VEC_W <= LW) begin : g_bad_vec
      $error("VEC_W must exceed the line index width");
   end

   logic          pri_cand_v;
   logic [LW-1:0] pri_cand_line;
   logic          sec_cand_v;
   logic [LW-1:0] sec_cand_line;

   cas_cand_pick #(
      .N_LINES(N_LINES), .HAS_SKIP(1'b1), .SKIP_LINE(CASC_LINE)
   ) u_pick_pri (
      .req(pri_req), .isr(pri_isr), .rot(pri_rot), .nest_en(nest_mode),
      .cand_v(pri_cand_v), .cand_line(pri_cand_line));

   cas_cand_pick #(
      .N_LINES(N_LINES), .HAS_SKIP(1'b0), .SKIP_LINE(CASC_LINE)
   ) u_pick_sec (
      .req(sec_req), .isr(sec_isr), .rot(sec_rot), .nest_en(nest_mode),
      .cand_v(sec_cand_v), .cand_line(sec_cand_line));

   cas_ack_seq #(
      .N_LINES(N_LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)
   ) u_ack (
      .clk(clk), .rst_n(rst_n), .int_ack(int_ack),
      .pri_v(pri_cand_v), .pri_line(pri_cand_line),
      .sec_v(sec_cand_v), .sec_line(sec_cand_line),
      .pri_base(pri_base), .sec_base(sec_base),
      .pri_ack(pri_ack), .pri_ack_line(pri_ack_line),
      .sec_ack(sec_ack), .sec_ack_line(sec_ack_line),
      .vec_valid(vec_valid), .vec(vec), .vec_line(vec_line));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_int  <= 1'b0;
         casc_set <= 1'b0;
      end else begin
         cpu_int  <= pri_cand_v && !int_ack;
         casc_set <= sec_cand_v && !int_ack;
      end
   end
endmodule

// File: rtl/cas_intc_seq_chk.sv
module cas_intc_seq_chk #(
   parameter int N_LINES = 8,
   parameter int VEC_W   = 8,
   localparam int LW = $clog2(N_LINES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_LINES-1:0] pri_req,
   input logic [N_LINES-1:0] sec_req,
   input logic               int_ack,
   input logic               pri_cand_v,
   input logic               sec_cand_v,
   input logic               cpu_int,
   input logic               casc_set,
   input logic               pri_ack,
   input logic [LW-1:0]      pri_ack_line,
   input logic               sec_ack,
   input logic [LW-1:0]      sec_ack_line,
   input logic               vec_valid,
   input logic [VEC_W-1:0]   vec,
   input logic [LW:0]        vec_line
);
   AST_INT_FOLLOWS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_cand_v && !int_ack) |=> cpu_int);                          // R1
   AST_INT_LOW_NO_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      !pri_cand_v |=> !cpu_int);                                      // R1
   AST_PRI_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pri_ack |-> pri_req[pri_ack_line]);                             // R2
   AST_SEC_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      sec_ack |-> sec_req[sec_ack_line]);                             // R2
   AST_CASC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_cand_v && !int_ack) |=> casc_set);                         // R4
   AST_SEC_WITH_CASC: assert property (@(posedge clk) disable iff (!rst_n)
      sec_ack |-> (pri_ack && pri_ack_line == LW'(2)));               // R6
   AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_ack || sec_ack) |-> int_ack);                              // R8
   AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> vec_valid);                                         // R9
   AST_NO_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ack |=> !vec_valid);                                       // R9
   AST_INT_DROP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !cpu_int);                                          // R10
   AST_VEC_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec[LW-1:0] == vec_line[LW-1:0]));               // R11
endmodule

bind cas_intc_seq cas_intc_seq_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pri_req(pri_req), .sec_req(sec_req),
   .int_ack(int_ack), .pri_cand_v(pri_cand_v), .sec_cand_v(sec_cand_v),
   .cpu_int(cpu_int), .casc_set(casc_set), .pri_ack(pri_ack),
   .pri_ack_line(pri_ack_line), .sec_ack(sec_ack), .sec_ack_line(sec_ack_line),
   .vec_valid(vec_valid), .vec(vec), .vec_line(vec_line));

// File: tb/cas_intc_seq_tb.sv
module cas_intc_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pri_req = '0, pri_isr = '0, pri_base = '0;
   logic [7:0] sec_req = '0, sec_isr = '0, sec_base = '0;
   logic [2:0] pri_rot = '0, sec_rot = '0;
   logic       nest_mode = 1'b0, int_ack = 1'b0;
   logic       cpu_int, casc_set, pri_ack, sec_ack, vec_valid;
   logic [2:0] pri_ack_line, sec_ack_line;
   logic [7:0] vec;
   logic [3:0] vec_line;
   int         n_checks = 0, n_errors = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   cas_intc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .pri_req(pri_req), .pri_isr(pri_isr),
      .pri_rot(pri_rot), .pri_base(pri_base), .nest_mode(nest_mode),
      .sec_req(sec_req), .sec_isr(sec_isr), .sec_rot(sec_rot),
      .sec_base(sec_base), .int_ack(int_ack), .cpu_int(cpu_int),
      .casc_set(casc_set), .pri_ack(pri_ack), .pri_ack_line(pri_ack_line),
      .sec_ack(sec_ack), .sec_ack_line(sec_ack_line), .vec_valid(vec_valid),
      .vec(vec), .vec_line(vec_line));

   task automatic chk(input string rq, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_in();
      pri_req = '0; pri_isr = '0; pri_rot = '0; sec_req = '0;
      sec_isr = '0; sec_rot = '0; nest_mode = 1'b0;
   endtask

   // Strobe acknowledge at a negedge; checks acks, the vector and cpu_int after it.
   task automatic do_ack(input string rq, input bit e_pa, input int e_pl,
                         input bit e_sa, input int e_sl, input int e_vec,
                         input int e_line, input bit e_int_after);
      int_ack = 1'b1;
      #1;
      chk({rq, " pri_ack"}, int'(pri_ack), int'(e_pa));
      if (e_pa) chk({rq, " pri_ack_line"}, int'(pri_ack_line), e_pl);
      chk({rq, " sec_ack"}, int'(sec_ack), int'(e_sa));
      if (e_sa) chk({rq, " sec_ack_line"}, int'(sec_ack_line), e_sl);
      @(negedge clk);
      int_ack = 1'b0;
      chk({rq, " vec_valid"}, int'(vec_valid), 1);
      chk({rq, " vec"}, int'(vec), e_vec);
      chk({rq, " vec_line"}, int'(vec_line), e_line);
      chk("R10 cpu_int low after ack", int'(cpu_int), 0);
      @(negedge clk);
      chk("R9 vec_valid one cycle", int'(vec_valid), 0);
      chk("R10 cpu_int re-evaluated", int'(cpu_int), int'(e_int_after));
   endtask

   task automatic t_reset();
      chk("R1 reset cpu_int", int'(cpu_int), 0);
      chk("R4 reset casc_set", int'(casc_set), 0);
      chk("R9 reset vec_valid", int'(vec_valid), 0);
   endtask

   task automatic t_rotation();
      clear_in(); pri_base = 8'h27;
      pri_req = 8'b0010_1000; settle();
      chk("R1 cpu_int with candidate", int'(cpu_int), 1);
      chk("R9 no vec without ack", int'(vec_valid), 0);
      do_ack("R5 rot0 line3", 1, 3, 0, 0, 8'h23, 3, 1);
      pri_rot = 3'd4; settle();
      do_ack("R2 rot4 line5", 1, 5, 0, 0, 8'h25, 5, 1);
      pri_rot = 3'd6; settle();
      do_ack("R11 rot6 wrap line3", 1, 3, 0, 0, 8'h23, 3, 1);
   endtask

   task automatic t_in_service();
      clear_in(); pri_req = 8'b0000_1000; pri_isr = 8'b0000_0010; settle();
      chk("R2 blocked by higher isr", int'(cpu_int), 0);
      pri_isr = 8'b0000_1000; settle();
      chk("R2 blocked by equal isr", int'(cpu_int), 0);
      pri_isr = 8'b0010_0000; settle();
      chk("R2 lower isr lets through", int'(cpu_int), 1);
      pri_req = '0; settle();
      chk("R1 cpu_int drops without candidate", int'(cpu_int), 0);
   endtask

   task automatic t_nested();
      clear_in(); pri_req = 8'b0001_0000; pri_isr = 8'b0000_0100; settle();
      chk("R3 isr2 blocks when nest off", int'(cpu_int), 0);
      nest_mode = 1'b1; settle();
      chk("R3 isr2 ignored when nest on", int'(cpu_int), 1);
      clear_in(); nest_mode = 1'b1;
      sec_req = 8'b0001_0000; sec_isr = 8'b0000_0100; settle();
      chk("R3 secondary isr2 still blocks", int'(casc_set), 0);
   endtask

   task automatic t_cascade();
      clear_in(); sec_req = 8'b0000_0010; settle();
      chk("R4 casc_set with sec candidate", int'(casc_set), 1);
      sec_req = '0; settle();
      chk("R4 casc_set low without candidate", int'(casc_set), 0);
      pri_base = 8'h08; sec_base = 8'h72;
      pri_req = 8'b0000_0100; sec_req = 8'b0100_0000; settle();
      do_ack("R6 cascaded line", 1, 2, 1, 6, 8'h76, 14, 1);
      sec_req = 8'b0100_0000; sec_isr = 8'b0000_0001; settle();
      do_ack("R7 secondary spurious", 1, 2, 0, 0, 8'h77, 15, 1);
   endtask

   task automatic t_spurious_pri();
      clear_in(); pri_base = 8'h0D; settle();
      do_ack("R8 primary spurious", 0, 0, 0, 0, 8'h0F, 7, 0);
      pri_req = 8'b0000_0001; settle();
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0; pri_req = '0;
      chk("R10 low in ack cycle+1", int'(cpu_int), 0);
      @(negedge clk);
      chk("R10 stays low after update", int'(cpu_int), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #20000;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_rotation();
      t_in_service();
      t_nested();
      t_cascade();
      t_spurious_pri();
      finish_run();
   end
endmodule